// File: doc/BRIEF.md
# Match and Capture Timer/Counter

A counter of up to 32 bits with a prescaler, four compare channels and four capture channels. It is controlled through a simple word-addressed register port. The counter advances on a tick. In timer mode the prescaler produces one tick every PLIM+1 clocks. In counter mode the prescaler instead counts chosen edges on one of the capture inputs.

Each compare channel checks its compare value on every tick. When the values are equal, the channel can do any mix of three things: set its interrupt flag, send the counter back to zero, or stop the counter. It can also change its output pin: drive it low, drive it high or flip it.

Each capture channel passes its input through a synchronizer. On a selected rising edge, falling edge or both, the channel copies the counter into its capture register and can raise a flag. A single interrupt line is the OR of all flags.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `match_out` is zero.
- R2: In timer mode (count control bits 1:0 = 0) with control bit 0 set and bit 1 clear, the count advances once every PLIM+1 clocks. The prescale register is at word 3. A limit of 0 therefore counts every clock. The count does not change when there is no tick.
- R3: While control bit 1 (word 1) is set, the count and the prescale count are held at zero, whatever else is written in the same cycle.
- R4: If compare-control bit 3n+1 (word 5) is set, a tick that finds the count equal to compare value n (word 6+n) loads zero. The count therefore cycles through 0..M, which is M+1 states.
- R5: If compare-control bit 3n+2 is set, a tick that finds a match on channel n clears control bit 0 and leaves the count at M.
- R6: If compare-control bit 3n is set, a match on channel n sets flag bit n (word 0), and `irq` goes high.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it set.
- R8: External-match word 15 holds the pin levels in bits 3:0 and a 2-bit action for channel n at bits 2n+5:2n+4. The actions are: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 flips it. The action is applied on each match of that channel, and `match_out` shows the levels.
- R9: Capture-control (word 10) bit 3n selects rising edges of `cap_in[n]` and bit 3n+1 selects falling edges. With both bits set, either edge captures. A selected edge, seen after the synchronizer, copies the count into capture word 11+n. No other event changes that word.
- R10: If capture-control bit 3n+2 is set, a capture on channel n sets flag bit 4+n.
- R11: Count control (word 28, byte offset 0x70) bits 1:0 set to 1, 2 or 3 make the counter advance on rising, falling or both edges of the capture input chosen by bits 3:2. In these modes clocks alone do not advance it.
- R12: The register words are: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale count, 5 compare control, 6-9 compare values, 10 capture control, 11-14 capture values, 15 external match, 28 count control. Unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| cap_in | input | N_CH | Capture and external count inputs |
| match_out | output | N_CH | External match levels |
| irq | output | 1 | OR of all flags |

## Verification
The counting path is tried with prescale limits of 0, 1, 2 and 4, both with and without a wrapping compare channel. This separates an off-by-one in the prescaler from an off-by-one in the wrap to zero. In external mode the same input is counted on rising edges, falling edges and both edges, which shows whether the edge selection is decoded correctly. Captures are driven with one input pattern on four channels that are set to rising, falling, both edges and none. The capture values and the flag show which channel reacted to which edge. The pin actions run on three channels at once with different compare values, so that keep, low, high and flip can each be seen apart.

// File: rtl/mct_pkg.sv
package mct_pkg;
   localparam int unsigned A_IFLAG  = 0;
   localparam int unsigned A_CTRL   = 1;
   localparam int unsigned A_COUNT  = 2;
   localparam int unsigned A_PLIM   = 3;
   localparam int unsigned A_PCNT   = 4;
   localparam int unsigned A_MCTL   = 5;
   localparam int unsigned A_MATCH0 = 6;
   localparam int unsigned A_CCTL   = 10;
   localparam int unsigned A_CAP0   = 11;
   localparam int unsigned A_EXTM   = 15;
   localparam int unsigned A_CMODE  = 28;

   typedef enum logic [1:0] {EM_KEEP = 2'd0, EM_LOW = 2'd1, EM_HIGH = 2'd2, EM_FLIP = 2'd3} em_act_e;
   typedef enum logic [1:0] {CM_TIMER = 2'd0, CM_RISE = 2'd1, CM_FALL = 2'd2, CM_BOTH = 2'd3} cnt_mode_e;

   // bit 0 interrupt, bit 1 wrap to zero, bit 2 stop
   typedef struct packed {
      logic stop;
      logic wrap;
      logic irq;
   } mch_ctl_t;
endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mct_edge_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
         prev <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         prev <= stg[STAGES-1];
      end
   end

   assign rise = stg[STAGES-1] & ~prev;
   assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             evt,
   input  logic             wr_count,
   input  logic             wr_pcnt,
   input  logic [CNT_W-1:0] wval,
   input  logic [CNT_W-1:0] plim,
   input  logic             hit_wrap,
   input  logic             hit_stop,
   output logic             tick,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] pcnt
);
   logic [CNT_W-1:0] count_q, pcnt_q;
   logic             step;

   assign step = run && !hold && evt;
   assign tick = step && (pcnt_q >= plim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         pcnt_q  <= '0;
      end else if (hold) begin
         count_q <= '0;
         pcnt_q  <= '0;
      end else begin
         if (wr_count)      count_q <= wval;
         else if (tick) begin
            if (hit_wrap)      count_q <= '0;
            else if (!hit_stop) count_q <= count_q + 1'b1;
         end
         if (wr_pcnt)       pcnt_q <= wval;
         else if (step)     pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
      end
   end

   assign count = count_q;
   assign pcnt  = pcnt_q;

   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (count_q == '0 && pcnt_q == '0)); // R3
   AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit_wrap && !wr_count) |=> count_q == '0); // R4
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !hold && !wr_count) |=> $stable(count_q)); // R2
endmodule

// File: rtl/mct_match_ch.sv
module mct_match_ch
   import mct_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] mval,
   input  mch_ctl_t         ctl,
   input  em_act_e          act,
   input  logic             lvl,
   output logic             hit,
   output logic             hit_irq,
   output logic             hit_wrap,
   output logic             hit_stop,
   output logic             lvl_nxt
);
   assign hit      = tick && (count == mval);
   assign hit_irq  = hit && ctl.irq;
   assign hit_wrap = hit && ctl.wrap;
   assign hit_stop = hit && ctl.stop;

   always_comb begin
      lvl_nxt = lvl;
      if (hit) begin
         unique case (act)
            EM_KEEP: lvl_nxt = lvl;
            EM_LOW:  lvl_nxt = 1'b0;
            EM_HIGH: lvl_nxt = 1'b1;
            EM_FLIP: lvl_nxt = ~lvl;
         endcase
      end
   end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
   import mct_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_CH-1:0]   cap_in,
   output logic [N_CH-1:0]   match_out,
   output logic              irq
);
   localparam int CTL_W = 3 * N_CH;
   localparam int ACT_W = 2 * N_CH;
   localparam logic [ADDR_W-1:0] W_IFLAG = ADDR_W'(A_IFLAG);
   localparam logic [ADDR_W-1:0] W_CTRL  = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] W_COUNT = ADDR_W'(A_COUNT);
   localparam logic [ADDR_W-1:0] W_PLIM  = ADDR_W'(A_PLIM);
   localparam logic [ADDR_W-1:0] W_PCNT  = ADDR_W'(A_PCNT);
   localparam logic [ADDR_W-1:0] W_MCTL  = ADDR_W'(A_MCTL);
   localparam logic [ADDR_W-1:0] W_CCTL  = ADDR_W'(A_CCTL);
   localparam logic [ADDR_W-1:0] W_EXTM  = ADDR_W'(A_EXTM);
   localparam logic [ADDR_W-1:0] W_CMODE = ADDR_W'(A_CMODE);

   if (N_CH < 1 || N_CH > 4) begin : g_bad_nch
      $error("mct_timer: N_CH must be 1..4");
   end
   if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("mct_timer: CNT_W must be 8..DATA_W");
   end
   if (ADDR_W < 5 || DATA_W < 12) begin : g_bad_map
      $error("mct_timer: register map needs ADDR_W>=5 and DATA_W>=12");
   end

   // register state
   logic             ctrl_en, ctrl_hold;
   logic [CNT_W-1:0] plim_q;
   logic [CTL_W-1:0] mctl_q, cctl_q;
   logic [N_CH-1:0]  flag_m, flag_c;
   logic [N_CH-1:0]  lvl_q;
   logic [ACT_W-1:0] act_q;
   logic [3:0]       cmode_q;
   logic [CNT_W-1:0] mval_q [N_CH];
   logic [CNT_W-1:0] cap_q  [N_CH];

   // datapath
   logic [CNT_W-1:0] count, pcnt;
   logic             tick, evt, run;
   logic [N_CH-1:0]  rise, fall, cap_load;
   logic [N_CH-1:0]  hit, hit_irq, hit_wrap, hit_stop, lvl_nxt;
   logic [3:0]       rise_x, fall_x;
   cnt_mode_e        cmode;
   logic [1:0]       csel;

   logic wr_iflag, wr_ctrl, wr_count, wr_plim, wr_pcnt, wr_mctl, wr_cctl, wr_extm, wr_cmode;
   logic unused_wd;

   assign wr_iflag = reg_wr && reg_addr == W_IFLAG;
   assign wr_ctrl  = reg_wr && reg_addr == W_CTRL;
   assign wr_count = reg_wr && reg_addr == W_COUNT;
   assign wr_plim  = reg_wr && reg_addr == W_PLIM;
   assign wr_pcnt  = reg_wr && reg_addr == W_PCNT;
   assign wr_mctl  = reg_wr && reg_addr == W_MCTL;
   assign wr_cctl  = reg_wr && reg_addr == W_CCTL;
   assign wr_extm  = reg_wr && reg_addr == W_EXTM;
   assign wr_cmode = reg_wr && reg_addr == W_CMODE;
   assign unused_wd = ^reg_wdata;

   // input synchronizer shared by capture and external counting
   mct_edge_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall)
   );

   for (genvar k = 0; k < 4; k++) begin : g_pad
      if (k < N_CH) begin : g_on
         assign rise_x[k] = rise[k];
         assign fall_x[k] = fall[k];
      end else begin : g_off
         assign rise_x[k] = 1'b0;
         assign fall_x[k] = 1'b0;
      end
   end

   assign cmode = cnt_mode_e'(cmode_q[1:0]);
   assign csel  = cmode_q[3:2];

   always_comb begin
      unique case (cmode)
         CM_TIMER: evt = 1'b1;
         CM_RISE:  evt = rise_x[csel];
         CM_FALL:  evt = fall_x[csel];
         CM_BOTH:  evt = rise_x[csel] | fall_x[csel];
      endcase
   end

   assign run = ctrl_en;

   mct_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .hold(ctrl_hold), .evt(evt),
      .wr_count(wr_count), .wr_pcnt(wr_pcnt), .wval(reg_wdata[CNT_W-1:0]),
      .plim(plim_q), .hit_wrap(|hit_wrap), .hit_stop(|hit_stop),
      .tick(tick), .count(count), .pcnt(pcnt)
   );

   // compare channels and capture channels
   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      mct_match_ch #(.CNT_W(CNT_W)) u_mch (
         .tick(tick), .count(count), .mval(mval_q[i]),
         .ctl(mch_ctl_t'(mctl_q[3*i +: 3])), .act(em_act_e'(act_q[2*i +: 2])),
         .lvl(lvl_q[i]), .hit(hit[i]), .hit_irq(hit_irq[i]), .hit_wrap(hit_wrap[i]),
         .hit_stop(hit_stop[i]), .lvl_nxt(lvl_nxt[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                          mval_q[i] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(A_MATCH0 + i)) mval_q[i] <= reg_wdata[CNT_W-1:0];
      end

      assign cap_load[i] = (rise[i] & cctl_q[3*i]) | (fall[i] & cctl_q[3*i+1]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cap_q[i] <= '0;
         else if (cap_load[i]) cap_q[i] <= count;
      end

      AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !cap_load[i] |=> $stable(cap_q[i])); // R9
   end

   // control, flags, pin levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_hold <= 1'b0;
         plim_q    <= '0;
         mctl_q    <= '0;
         cctl_q    <= '0;
         flag_m    <= '0;
         flag_c    <= '0;
         lvl_q     <= '0;
         act_q     <= '0;
         cmode_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en   <= reg_wdata[0];
            ctrl_hold <= reg_wdata[1];
         end else if (|hit_stop) begin
            ctrl_en <= 1'b0;
         end
         if (wr_plim)  plim_q  <= reg_wdata[CNT_W-1:0];
         if (wr_mctl)  mctl_q  <= reg_wdata[CTL_W-1:0];
         if (wr_cctl)  cctl_q  <= reg_wdata[CTL_W-1:0];
         if (wr_cmode) cmode_q <= reg_wdata[3:0];
         flag_m <= (flag_m & ~(wr_iflag ? reg_wdata[N_CH-1:0] : '0)) | hit_irq;
         for (int c = 0; c < N_CH; c++) begin
            flag_c[c] <= (flag_c[c] & ~(wr_iflag & reg_wdata[4+c]))
                         | (cap_load[c] & cctl_q[3*c+2]);
         end
         if (wr_extm) begin
            lvl_q <= reg_wdata[N_CH-1:0];
            act_q <= reg_wdata[4 +: ACT_W];
         end else begin
            lvl_q <= lvl_nxt;
         end
      end
   end

   assign match_out = lvl_q;
   assign irq       = |{flag_m, flag_c};

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         W_IFLAG: begin
            reg_rdata[N_CH-1:0] = flag_m;
            reg_rdata[4 +: N_CH] = flag_c;
         end
         W_CTRL:  reg_rdata[1:0]       = {ctrl_hold, ctrl_en};
         W_COUNT: reg_rdata[CNT_W-1:0] = count;
         W_PLIM:  reg_rdata[CNT_W-1:0] = plim_q;
         W_PCNT:  reg_rdata[CNT_W-1:0] = pcnt;
         W_MCTL:  reg_rdata[CTL_W-1:0] = mctl_q;
         W_CCTL:  reg_rdata[CTL_W-1:0] = cctl_q;
         W_EXTM: begin
            reg_rdata[N_CH-1:0] = lvl_q;
            reg_rdata[4 +: ACT_W] = act_q;
         end
         W_CMODE: reg_rdata[3:0] = cmode_q;
         default: begin
            for (int i = 0; i < N_CH; i++) begin
               if (reg_addr == ADDR_W'(A_MATCH0 + i)) reg_rdata[CNT_W-1:0] = mval_q[i];
               if (reg_addr == ADDR_W'(A_CAP0 + i))   reg_rdata[CNT_W-1:0] = cap_q[i];
            end
         end
      endcase
   end

   AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hit_stop) && !wr_ctrl) |=> !ctrl_en); // R5
   AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_irq) |=> irq); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_iflag |=> (({flag_m, flag_c} & $past({flag_m, flag_c})) == $past({flag_m, flag_c}))); // R7
   AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|hit) && !wr_extm) |=> $stable(match_out)); // R8
endmodule

// File: tb/mct_timer_tb.sv
module mct_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mct_timer dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
      .match_out(match_out), .irq(irq)
   );

   typedef struct packed {
      int plim;
      int mval;
      int mctl;
      int cyc;
      int expc;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{0, 100, 0, 10, 10},
      '{2, 100, 0, 10, 3},
      '{0, 4,   2, 12, 2},
      '{1, 3,   2, 13, 2},
      '{4, 100, 0, 23, 4}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 5'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulses(input int bit_i, input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk); cap_in[bit_i] = 1'b1;
         repeat (3) @(negedge clk);
         cap_in[bit_i] = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (VEC[i]) begin end
      for (int a = 0; a < 29; a++) begin
         rd(a, v);
         chk($sformatf("R1 reset word %0d", a), v, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 match_out", {28'b0, match_out}, 32'h0);

      // R12 map: limit reads back at word 3, unmapped reads zero
      wr(3, 32'h5A);
      rd(3, v); chk("R12 plim readback", v, 32'h5A);
      wr(20, 32'hFFFF);
      rd(20, v); chk("R12 unmapped", v, 32'h0);

      // R2 / R4 table
      for (int i = 0; i < 5; i++) begin
         wr(1, 32'h2);
         wr(3, VEC[i].plim);
         wr(6, VEC[i].mval);
         wr(5, VEC[i].mctl);
         wr(1, 32'h1);
         repeat (VEC[i].cyc) @(posedge clk);
         rd(2, v);
         chk($sformatf("R2 R4 vector %0d count", i), v, VEC[i].expc);
      end

      // R3 hold
      wr(1, 32'h3);
      repeat (5) @(posedge clk);
      rd(2, v); chk("R3 count held", v, 32'h0);
      rd(4, v); chk("R3 prescale held", v, 32'h0);

      // R5 stop on match of channel 1 (bit 5)
      wr(1, 32'h2); wr(3, 0); wr(7, 5); wr(5, 32'h20); wr(1, 32'h1);
      repeat (20) @(posedge clk);
      rd(2, v); chk("R5 count at match", v, 32'd5);
      rd(1, v); chk("R5 enable cleared", v, 32'h0);

      // R6 / R7 interrupt on channel 2 (bit 6)
      wr(0, 32'hFF);
      wr(1, 32'h2); wr(8, 3); wr(5, 32'h40); wr(1, 32'h1);
      repeat (10) @(posedge clk);
      rd(0, v); chk("R6 flag", v, 32'h04);
      chk("R6 irq", {31'b0, irq}, 32'h1);
      wr(0, 32'h0);
      rd(0, v); chk("R7 write 0 keeps", v, 32'h04);
      wr(0, 32'h04);
      rd(0, v); chk("R7 write 1 clears", v, 32'h0);
      chk("R7 irq low", {31'b0, irq}, 32'h0);

      // R8 pin actions: ch0 flip, ch1 high, ch2 low, ch3 keep
      wr(1, 32'h2); wr(3, 0);
      wr(6, 2); wr(7, 1); wr(8, 0); wr(9, 32'h7FFF);
      wr(5, 32'h2);
      wr(15, 32'h1BC);
      wr(1, 32'h1);
      repeat (9) @(posedge clk);
      @(negedge clk);
      chk("R8 match_out", {28'b0, match_out}, 32'hB);
      rd(15, v); chk("R8 ext word", v, 32'h1BB);

      // R9 / R10 capture: ch0 rise, ch1 fall, ch2 both+irq, ch3 none
      wr(1, 32'h0); wr(5, 0); wr(28, 0);
      wr(2, 32'h1234);
      wr(10, 32'h1D1);
      wr(0, 32'hFF);
      @(negedge clk); cap_in = 4'hF;
      repeat (6) @(negedge clk);
      rd(11, v); chk("R9 cap0 rise", v, 32'h1234);
      rd(12, v); chk("R9 cap1 no rise", v, 32'h0);
      rd(13, v); chk("R9 cap2 rise", v, 32'h1234);
      rd(14, v); chk("R9 cap3 off", v, 32'h0);
      rd(0, v);  chk("R10 capture flag", v, 32'h40);
      wr(2, 32'h55);
      @(negedge clk); cap_in = 4'h0;
      repeat (6) @(negedge clk);
      rd(11, v); chk("R9 cap0 no fall", v, 32'h1234);
      rd(12, v); chk("R9 cap1 fall", v, 32'h55);
      rd(13, v); chk("R9 cap2 fall", v, 32'h55);
      rd(14, v); chk("R9 cap3 off", v, 32'h0);

      // R11 external counting on input 3
      wr(10, 0); wr(0, 32'hFF);
      wr(1, 32'h2); wr(3, 0); wr(28, 32'hD); wr(1, 32'h1);
      pulses(3, 4);
      repeat (6) @(negedge clk);
      rd(2, v); chk("R11 rising edges", v, 32'd4);
      wr(1, 32'h2); wr(28, 32'hE); wr(1, 32'h1);
      pulses(3, 2);
      repeat (6) @(negedge clk);
      rd(2, v); chk("R11 falling edges", v, 32'd2);
      wr(1, 32'h2); wr(28, 32'hF); wr(1, 32'h1);
      pulses(3, 3);
      repeat (6) @(negedge clk);
      rd(2, v); chk("R11 both edges", v, 32'd6);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule